// File: doc/BRIEF.md
# Two-Lane SPI Master Serializer

This block is an SPI master whose shift engine drives two data lanes at once. Each lane has its own outgoing and incoming data line. Both lanes share one serial clock and one active-low chip select. For each transfer the host gives a byte count and a lane mode. The block then pulls transmit bytes from a byte-stream port, serializes them onto the lanes, and returns the sampled receive bytes one at a time in buffer order.

Three lane modes exist.

- **Single** (the default) uses lane 0 only, as a conventional one-lane master.
- **Mirror** broadcasts every transmit byte on all lanes in the same word period. It is a write-only mode, so no receive data is returned.
- **Stripe** gives each lane its own byte in the same word period. Consecutive buffer bytes alternate across the lanes, in both directions.

Only SPI mode 0 with 8-bit words is supported. The serial clock comes from the system clock through a programmable half-period count. A request whose length does not suit the chosen mode is refused with an error pulse, and no bus activity takes place.

Top module: `mlane_spi_master`

## Requirements
- R1: With `xfer_mode` = 0 (single), byte i of the transmit stream is shifted out on `sdo[0]` as word i, and every other lane's `sdo` is held at 0 while the serial clock runs.
- R2: In single mode, the byte sampled on `sdi[0]` in word i is returned as the i-th `rx_data` byte with a one-cycle `rx_valid` strobe.
- R3: With `xfer_mode` = 1 (mirror), transmit byte i is shifted out on every lane in word i, with identical bit sequences on all lanes.
- R4: In mirror mode `rx_valid` never asserts.
- R5: With `xfer_mode` = 2 (stripe), transmit byte j goes to lane j mod 2 in word j div 2.
- R6: In stripe mode, the receive bytes of word w are returned as lane 0's byte followed by lane 1's byte. For example, 0x11 on lane 0 and 0x88 on lane 1 give 0x11 then 0x88.
- R7: A start request is refused in three cases: a length of 0, `xfer_mode` = 3, or a stripe request with an odd length. A refused request raises `len_err` for exactly one cycle. While it is refused, `cs_n` stays high, `sclk` stays low, and `tx_pop` stays low.
- R8: Bits go out MSB first. `sdo` changes only while `sclk` is low. `sdi` is sampled on the rising edge of `sclk`, which idles low.
- R9: `cs_n` is low for the whole transfer and high at reset. A transfer has 8·W rising edges of `sclk`, where W is the length in bytes for single and mirror, and the length divided by 2 for stripe.
- R10: `done` is a one-cycle pulse. It rises one clock after `cs_n` returns high.
- R11: Each `sclk` phase lasts `sclk_half` system clocks, with a value of 0 treated as 1. Consecutive rising edges inside a word are therefore 2·`sclk_half` clocks apart.
- R12: `tx_pop` asserts once per consumed transmit byte, exactly as many times as the requested length. `tx_data` is taken in the same cycle as `tx_pop`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a transfer; sampled while idle |
| xfer_mode | input | 2 | Lane mode: 0 single, 1 mirror, 2 stripe, 3 refused |
| xfer_len | input | LEN_W | Transfer length in bytes |
| sclk_half | input | DIV_W | System clocks per serial clock phase |
| tx_data | input | 8 | Next transmit byte of the stream |
| tx_pop | output | 1 | Transmit byte consumed this cycle |
| rx_data | output | 8 | Received byte in buffer order |
| rx_valid | output | 1 | Strobe for `rx_data` |
| done | output | 1 | Transfer finished pulse |
| len_err | output | 1 | Request refused pulse |
| sclk | output | 1 | Serial clock (idle low) |
| cs_n | output | 1 | Chip select, active low |
| sdo | output | NUM_LANES | Per-lane serial data out |
| sdi | input | NUM_LANES | Per-lane serial data in |

## Verification
A bench-side peripheral drives a distinct byte sequence on each lane and records every lane's outgoing bits on the rising clock edges.

- **Single-mode runs** (one byte and several bytes) show whether lane 0 alone carries data and whether the idle lane stays low.
- **Mirror runs** show whether both lanes carry the same bits and whether receive capture is suppressed.
- **Stripe runs** use the 0x11/0x88 pair and a longer stream. They tell apart a correct alternating lane order from a swapped order or a per-lane grouping.
- **Refused requests and a zero divider** probe the error path and the clock-rate floor.

// File: rtl/mls_pkg.sv
package mls_pkg;

    typedef enum logic [1:0] {
        LM_SINGLE = 2'd0,
        LM_MIRROR = 2'd1,
        LM_STRIPE = 2'd2,
        LM_RSVD   = 2'd3
    } lane_mode_e;

    typedef enum logic [1:0] {
        CS_IDLE  = 2'd0,
        CS_LOAD  = 2'd1,
        CS_SHIFT = 2'd2,
        CS_DONE  = 2'd3
    } ctl_state_e;

endpackage

// File: rtl/mls_sclk_div.sv
module mls_sclk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] half_period,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_t;

    div_t             st_d, st_q;
    logic [DIV_W-1:0] limit;

    always_comb begin
        limit = (half_period == '0) ? '0 : half_period - DIV_W'(1);
        st_d  = st_q;
        tick  = 1'b0;
        if (!en) begin
            st_d.cnt = '0;
        end else if (st_q.cnt >= limit) begin
            tick     = 1'b1;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/mls_lane.sv
module mls_lane #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              shift_out,
    input  logic              sample,
    input  logic              sdi,
    output logic              sdo,
    output logic [WORD_W-1:0] rx_word
);

    typedef struct packed {
        logic [WORD_W-1:0] tx_sh;
        logic [WORD_W-1:0] rx_sh;
    } lane_t;

    lane_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.tx_sh = load_word;
        end else if (shift_out) begin
            st_d.tx_sh = {st_q.tx_sh[WORD_W-2:0], 1'b0};
        end
        if (sample) begin
            st_d.rx_sh = {st_q.rx_sh[WORD_W-2:0], sdi};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdo     = st_q.tx_sh[WORD_W-1];
    assign rx_word = st_q.rx_sh;

endmodule

// File: rtl/mls_rx_pack.sv
module mls_rx_pack #(
    parameter int NUM_LANES = 2,
    parameter int WORD_W    = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              capture,
    input  logic                              all_lanes,
    input  logic [NUM_LANES-1:0][WORD_W-1:0]  lane_words,
    output logic [WORD_W-1:0]                 rx_data,
    output logic                              rx_valid
);

    localparam int IDX_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;
    localparam int CNT_W = $clog2(NUM_LANES + 1);

    typedef struct packed {
        logic [NUM_LANES-1:0][WORD_W-1:0] snap;
        logic [IDX_W-1:0]                 idx;
        logic [CNT_W-1:0]                 left;
        logic [WORD_W-1:0]                data;
        logic                             valid;
    } pack_t;

    pack_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (capture) begin
            st_d.snap = lane_words;
            st_d.idx  = '0;
            st_d.left = all_lanes ? CNT_W'(NUM_LANES) : CNT_W'(1);
        end else if (st_q.left != '0) begin
            st_d.data  = st_q.snap[st_q.idx];
            st_d.valid = 1'b1;
            st_d.idx   = st_q.idx + IDX_W'(1);
            st_d.left  = st_q.left - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_data  = st_q.data;
    assign rx_valid = st_q.valid;

endmodule

// File: rtl/mlane_spi_master.sv
module mlane_spi_master
    import mls_pkg::*;
#(
    parameter int NUM_LANES = 2,
    parameter int LEN_W     = 8,
    parameter int DIV_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [1:0]           xfer_mode,
    input  logic [LEN_W-1:0]     xfer_len,
    input  logic [DIV_W-1:0]     sclk_half,
    input  logic [7:0]           tx_data,
    output logic                 tx_pop,
    output logic [7:0]           rx_data,
    output logic                 rx_valid,
    output logic                 done,
    output logic                 len_err,
    output logic                 sclk,
    output logic                 cs_n,
    output logic [NUM_LANES-1:0] sdo,
    input  logic [NUM_LANES-1:0] sdi
);

    localparam int WORD_W = 8;
    localparam int BIT_W  = $clog2(WORD_W);
    localparam int LIDX_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;

    typedef struct packed {
        ctl_state_e        state;
        lane_mode_e        mode;
        logic [LEN_W-1:0]  words_left;
        logic [LIDX_W-1:0] ld_idx;
        logic [BIT_W-1:0]  bit_idx;
        logic              sclk;
        logic              cs_n;
        logic              done;
        logic              err;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{
        state:      CS_IDLE,
        mode:       LM_SINGLE,
        words_left: '0,
        ld_idx:     '0,
        bit_idx:    '0,
        sclk:       1'b0,
        cs_n:       1'b1,
        done:       1'b0,
        err:        1'b0
    };

    ctl_t st_d, st_q;

    logic                             tick;
    logic                             rise, fall;
    logic                             last_bit;
    logic                             capture;
    logic                             req_bad;
    lane_mode_e                       req_mode;
    logic [NUM_LANES-1:0]             lane_load;
    logic [NUM_LANES-1:0][WORD_W-1:0] lane_val;
    logic [NUM_LANES-1:0][WORD_W-1:0] lane_rx;
    logic                             shift_out;
    logic [1:0]                       cur_mode;

    // Serial clock phase counter, running only while shifting
    mls_sclk_div #(.DIV_W(DIV_W)) i_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (st_q.state == CS_SHIFT),
        .half_period (sclk_half),
        .tick        (tick)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.err  = 1'b0;
        tx_pop    = 1'b0;
        capture   = 1'b0;

        req_mode = lane_mode_e'(xfer_mode);
        req_bad  = (req_mode == LM_RSVD) || (xfer_len == '0) ||
                   ((req_mode == LM_STRIPE) &&
                    ((xfer_len % LEN_W'(NUM_LANES)) != '0));

        rise     = (st_q.state == CS_SHIFT) && tick && !st_q.sclk;
        fall     = (st_q.state == CS_SHIFT) && tick &&  st_q.sclk;
        last_bit = (st_q.bit_idx == BIT_W'(WORD_W - 1));

        unique case (st_q.state)
            CS_IDLE: begin
                if (start) begin
                    if (req_bad) begin
                        st_d.err = 1'b1;
                    end else begin
                        st_d.mode       = req_mode;
                        st_d.words_left = (req_mode == LM_STRIPE) ?
                                          xfer_len / LEN_W'(NUM_LANES) : xfer_len;
                        st_d.ld_idx     = '0;
                        st_d.bit_idx    = '0;
                        st_d.cs_n       = 1'b0;
                        st_d.state      = CS_LOAD;
                    end
                end
            end
            CS_LOAD: begin
                tx_pop = 1'b1;
                if ((st_q.mode != LM_STRIPE) ||
                    (st_q.ld_idx == LIDX_W'(NUM_LANES - 1))) begin
                    st_d.state = CS_SHIFT;
                end else begin
                    st_d.ld_idx = st_q.ld_idx + LIDX_W'(1);
                end
            end
            CS_SHIFT: begin
                if (tick) begin
                    st_d.sclk = !st_q.sclk;
                end
                if (fall) begin
                    if (last_bit) begin
                        st_d.bit_idx    = '0;
                        st_d.words_left = st_q.words_left - LEN_W'(1);
                        capture         = (st_q.mode != LM_MIRROR);
                        if (st_q.words_left == LEN_W'(1)) begin
                            st_d.cs_n  = 1'b1;
                            st_d.state = CS_DONE;
                        end else begin
                            st_d.ld_idx = '0;
                            st_d.state  = CS_LOAD;
                        end
                    end else begin
                        st_d.bit_idx = st_q.bit_idx + BIT_W'(1);
                    end
                end
            end
            CS_DONE: begin
                st_d.done  = 1'b1;
                st_d.state = CS_IDLE;
            end
            default: st_d = CTL_RESET;
        endcase

        // Lane loading: which lanes take a byte this cycle, and which byte
        for (int k = 0; k < NUM_LANES; k++) begin
            lane_load[k] = 1'b0;
            lane_val[k]  = tx_data;
            if (st_q.state == CS_LOAD) begin
                unique case (st_q.mode)
                    LM_STRIPE: lane_load[k] = (st_q.ld_idx == LIDX_W'(k));
                    LM_MIRROR: lane_load[k] = 1'b1;
                    default: begin
                        lane_load[k] = 1'b1;
                        if (k != 0) lane_val[k] = '0;
                    end
                endcase
            end
        end

        shift_out = fall && !last_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CTL_RESET;
        else        st_q <= st_d;
    end

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        mls_lane #(.WORD_W(WORD_W)) i_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (lane_load[k]),
            .load_word (lane_val[k]),
            .shift_out (shift_out),
            .sample    (rise),
            .sdi       (sdi[k]),
            .sdo       (sdo[k]),
            .rx_word   (lane_rx[k])
        );
    end

    mls_rx_pack #(.NUM_LANES(NUM_LANES), .WORD_W(WORD_W)) i_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (capture),
        .all_lanes  (st_q.mode == LM_STRIPE),
        .lane_words (lane_rx),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid)
    );

    assign sclk     = st_q.sclk;
    assign cs_n     = st_q.cs_n;
    assign done     = st_q.done;
    assign len_err  = st_q.err;
    assign cur_mode = st_q.mode;

endmodule

// File: rtl/mls_spi_checker.sv
module mls_spi_checker
    import mls_pkg::*;
#(
    parameter int NUM_LANES = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sclk,
    input logic                 cs_n,
    input logic [NUM_LANES-1:0] sdo,
    input logic                 done,
    input logic                 len_err,
    input logic                 rx_valid,
    input logic                 tx_pop,
    input logic [1:0]           cur_mode
);

    a_r9_sclk_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);

    a_r10_done_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> done);

    a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_refusal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> (cs_n && !sclk && !tx_pop));

    a_r8_sdo_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdo));

    a_r3_mirror_equal: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_mode == LM_MIRROR) && sclk) |-> (sdo == {NUM_LANES{sdo[0]}}));

    a_r4_mirror_no_rx: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_mode == LM_MIRROR) && !cs_n) |-> !rx_valid);

    a_r1_idle_lanes_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_mode == LM_SINGLE) && sclk) |-> ((sdo >> 1) == '0));

endmodule

bind mlane_spi_master mls_spi_checker #(.NUM_LANES(NUM_LANES)) i_mls_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk     (sclk),
    .cs_n     (cs_n),
    .sdo      (sdo),
    .done     (done),
    .len_err  (len_err),
    .rx_valid (rx_valid),
    .tx_pop   (tx_pop),
    .cur_mode (cur_mode)
);

// File: tb/test_mlane_spi_master.sv
module test_mlane_spi_master;

    localparam int CLK_PERIOD = 10;
    localparam int NL         = 2;
    localparam int LEN_W      = 8;
    localparam int DIV_W      = 8;
    localparam int MAXB       = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [1:0]       xfer_mode = 2'd0;
    logic [LEN_W-1:0] xfer_len = '0;
    logic [DIV_W-1:0] sclk_half = 8'd1;
    logic [7:0]       tx_data;
    logic             tx_pop;
    logic [7:0]       rx_data;
    logic             rx_valid;
    logic             done;
    logic             len_err;
    logic             sclk;
    logic             cs_n;
    logic [NL-1:0]    sdo;
    logic [NL-1:0]    sdi;

    int n_chk  = 0;
    int n_fail = 0;

    logic [7:0] tx_mem [MAXB];
    logic [7:0] pmem   [NL][MAXB];
    logic       got    [NL][8*MAXB];
    int  tx_idx   = 0;
    int  fall_cnt = 0;
    int  rise_cnt = 0;
    int  done_cnt = 0;
    int  err_cnt  = 0;
    bit  cs_low_seen = 1'b0;
    bit  cs_p1 = 1'b1;
    bit  cs_p2 = 1'b1;
    time t_r0, t_r1;
    logic [7:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mlane_spi_master #(.NUM_LANES(NL), .LEN_W(LEN_W), .DIV_W(DIV_W)) i_mlane_spi_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .xfer_mode (xfer_mode),
        .xfer_len  (xfer_len),
        .sclk_half (sclk_half),
        .tx_data   (tx_data),
        .tx_pop    (tx_pop),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .done      (done),
        .len_err   (len_err),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .sdo       (sdo),
        .sdi       (sdi)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Transmit stream source
    assign tx_data = tx_mem[tx_idx % MAXB];
    always @(posedge clk) if (tx_pop) tx_idx++;

    // Peripheral model: drives on falling edges, records on rising edges
    for (genvar k = 0; k < NL; k++) begin : g_periph
        assign sdi[k] = pmem[k][(fall_cnt / 8) % MAXB][7 - (fall_cnt % 8)];
    end

    always @(negedge cs_n) begin
        fall_cnt = 0;
        rise_cnt = 0;
    end

    always @(negedge sclk) fall_cnt++;

    always @(posedge sclk) begin
        for (int k = 0; k < NL; k++) got[k][rise_cnt % (8*MAXB)] = sdo[k];
        if (rise_cnt == 0) t_r0 = $time;
        if (rise_cnt == 1) t_r1 = $time;
        rise_cnt++;
    end

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (!cs_n) cs_low_seen = 1'b1;
            if (len_err) err_cnt++;
            if (done) begin
                done_cnt++;
                check(cs_n && cs_p1 && !cs_p2, "R10", "done one cycle after cs_n rise",
                      {cs_n, cs_p1, cs_p2}, 3'b110);
            end
            if (rx_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4/R2/R6", "unexpected rx byte", rx_data, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(rx_data == e, "R2/R6", "rx byte order", rx_data, e);
                end
            end
        end
        cs_p2 = cs_p1;
        cs_p1 = cs_n;
    end

    function automatic logic [7:0] lane_byte(input int k, input int w);
        logic [7:0] b;
        for (int i = 0; i < 8; i++) b[7-i] = got[k][8*w + i];
        return b;
    endfunction

    task automatic fill(input int seed);
        for (int i = 0; i < MAXB; i++) begin
            tx_mem[i]  = 8'((i * 37 + seed * 11 + 5) ^ (i << 4));
            pmem[0][i] = 8'((i * 53 + seed * 7 + 3) ^ 8'h5a);
            pmem[1][i] = 8'((i * 29 + seed * 13 + 9) ^ 8'ha5);
        end
    endtask

    task automatic run_xfer(input int mode, input int len, input int div);
        int words, eff, d0, guard;
        logic [7:0] e;
        words = (mode == 2) ? len / NL : len;
        eff   = (div == 0) ? 1 : div;
        if (mode == 0) begin
            for (int w = 0; w < words; w++) exp_q.push_back(pmem[0][w]);
        end else if (mode == 2) begin
            for (int w = 0; w < words; w++)
                for (int k = 0; k < NL; k++) exp_q.push_back(pmem[k][w]);
        end
        tx_idx = 0;
        d0 = done_cnt;
        @(negedge clk);
        xfer_mode = 2'(mode);
        xfer_len  = LEN_W'(len);
        sclk_half = DIV_W'(div);
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (done_cnt == d0 && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        check(done_cnt == d0 + 1, "R10", "done pulse seen", done_cnt - d0, 1);
        repeat (3) @(negedge clk);
        check(tx_idx == len, "R12", "tx_pop count", tx_idx, len);
        check(rise_cnt == 8 * words, "R9", "sclk rising edges", rise_cnt, 8 * words);
        check((t_r1 - t_r0) == time'(2 * eff * CLK_PERIOD), "R11", "sclk period",
              int'(t_r1 - t_r0), 2 * eff * CLK_PERIOD);
        check(exp_q.size() == 0, "R2/R6", "rx bytes outstanding", exp_q.size(), 0);
        exp_q.delete();
        for (int w = 0; w < words; w++) begin
            for (int k = 0; k < NL; k++) begin
                if (mode == 0) begin
                    e = (k == 0) ? tx_mem[w] : 8'h00;
                    check(lane_byte(k, w) == e, "R1", "single lane data", lane_byte(k, w), e);
                end else if (mode == 1) begin
                    e = tx_mem[w];
                    check(lane_byte(k, w) == e, "R3", "mirror lane data", lane_byte(k, w), e);
                end else begin
                    e = tx_mem[w * NL + k];
                    check(lane_byte(k, w) == e, "R5", "stripe lane data", lane_byte(k, w), e);
                end
            end
        end
    endtask

    task automatic run_bad(input int mode, input int len);
        int e0, r0;
        e0 = err_cnt;
        r0 = rise_cnt;
        tx_idx = 0;
        @(negedge clk);
        cs_low_seen = 1'b0;
        xfer_mode = 2'(mode);
        xfer_len  = LEN_W'(len);
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        check(err_cnt == e0 + 1, "R7", "len_err single pulse", err_cnt - e0, 1);
        check(!cs_low_seen, "R7", "cs_n stays high", cs_low_seen, 0);
        check(tx_idx == 0 && rise_cnt == r0, "R7", "no pops or clocks", tx_idx, 0);
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        fill(0);
        repeat (4) @(negedge clk);
        check(cs_n == 1'b1 && sclk == 1'b0 && done == 1'b0 && rx_valid == 1'b0 && tx_pop == 1'b0,
              "R9", "reset state", {cs_n, sclk, done, rx_valid, tx_pop}, 5'b10000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        fill(1); run_xfer(0, 3, 2);          // R1 R2 single, several bytes
        fill(2); run_xfer(0, 1, 1);          // R1 R2 single, minimum length
        fill(3); run_xfer(1, 4, 3);          // R3 R4 mirror
        fill(4);
        pmem[0][0] = 8'h11;
        pmem[1][0] = 8'h88;
        run_xfer(2, 2, 2);                   // R5 R6 stripe, example pair
        fill(5); run_xfer(2, 6, 0);          // R5 R6 R11 stripe, zero divider
        run_bad(2, 3);                       // R7 odd stripe length
        run_bad(0, 0);                       // R7 zero length
        run_bad(3, 2);                       // R7 reserved mode
        fill(6); run_xfer(0, 2, 1);          // R8 recovery after refusals
        report();
        $finish;
    end

endmodule